// File: doc/BRIEF.md
# VPW Pulse-Width Symbol Classifier

This block sits behind the input synchroniser of a single-wire variable-pulse-width bus receiver. It times every constant-level stretch of the bus in cycles of a timing clock. When the level changes, it names the stretch that just ended. The result is a data bit, a frame symbol, or an invalid pulse. A one-cycle strobe carries the class code and the level of that stretch. A high bus is the active level and a low bus is the passive level.

The decision windows sit back to back. Each upper limit equals the next lower limit, so every interval length falls into exactly one class, resolved to one clock cycle. The meaning of the two middle windows is mirrored between levels: a short passive pulse and a long active pulse both carry a 0. While the bus rests passive, two strobes give the framing layer early warning with no edge needed. The first marks the end of data and the second marks inter-frame idle.

The length of an interval is the number of rising clock edges at which the bus was sampled at that level. The limits are parameters in clock counts. Their defaults (34, 96, 163, 239) suit a 1 MHz timing clock.

Top module: `vpw_sym_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `sym_valid`, `eod_strobe` and `idle_strobe` are low, and the bus is assumed passive.
- R2: A level change sampled on the bus causes `sym_valid` to be high for one cycle, on the clock after the change is sampled. Together with it, `sym_level` gives the level of the interval that ended (1 active, 0 passive). No other event raises `sym_valid`.
- R3: An interval shorter than 34 counts is reported with class code 0 (invalid) at either level.
- R4: A passive interval of 34 to 95 counts gives code 1 (logic 0), and one of 96 to 162 counts gives code 2 (logic 1).
- R5: An active interval of 34 to 95 counts gives code 2 (logic 1), and one of 96 to 162 counts gives code 1 (logic 0).
- R6: A passive interval of 163 to 238 counts gives code 3 (end of data), and one of 239 counts or more gives code 5 (idle).
- R7: An active interval of 163 to 238 counts gives code 4 (start of frame), and one of 239 counts or more gives code 6 (break).
- R8: The interval counter stops at its maximum (511 by default). An interval longer than that is still reported with the class for the longest window.
- R9: During a passive interval, `eod_strobe` pulses once, on the clock at which the count reaches 163. A passive interval of 162 counts produces no pulse.
- R10: During a passive interval, `idle_strobe` pulses once, on the clock at which the count reaches 239. A passive interval of 238 counts produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock; one period is the width resolution |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 1 | Synchronised bus level, 1 = active |
| sym_valid | output | 1 | One-cycle strobe: an interval has ended |
| sym_level | output | 1 | Level of the interval that ended, 1 = active |
| sym_class | output | 3 | Class code of the interval that ended |
| eod_strobe | output | 1 | Passive interval has reached the end-of-data length |
| idle_strobe | output | 1 | Passive interval has reached the idle length |

## Verification
If the interval counter is off by one, it shows at the ports only when a pulse lands on a window boundary. The off-by-one result appears in the class code on the next edge, or as an end-of-data or idle strobe one clock early, one clock late, or missing. The stimulus therefore places pulses on both sides of every boundary at both levels. If the level register holds the wrong value, the class comes out mirrored (logic 0 read as logic 1, or start of frame read as end of data) in the very next `sym_valid` cycle. A counter that wraps instead of saturating turns a very long active pulse into a short-pulse class.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic [2:0] {
    CLS_INVALID = 3'd0,
    CLS_BIT0    = 3'd1,
    CLS_BIT1    = 3'd2,
    CLS_EOD     = 3'd3,
    CLS_SOF     = 3'd4,
    CLS_IDLE    = 3'd5,
    CLS_BREAK   = 3'd6
  } vpw_class_e;

  localparam logic LVL_PASSIVE = 1'b0;
  localparam logic LVL_ACTIVE  = 1'b1;

endpackage

// File: rtl/vpw_interval_ctr.sv
module vpw_interval_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_in,
  output logic             lvl_q,
  output logic             edge_det,
  output logic [CNT_W-1:0] cnt_q
);
  import vpw_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             lvl_en;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    edge_det = bus_in ^ lvl_q;
    lvl_en   = edge_det;
    cnt_en   = edge_det | (cnt_q != CNT_MAX);
    if (edge_det) cnt_d = CNT_ONE;
    else          cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_PASSIVE;
      cnt_q <= '0;
    end else begin
      if (lvl_en) lvl_q <= bus_in;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX && !$past(edge_det)) |-> (cnt_q == CNT_MAX));

endmodule

// File: rtl/vpw_sym_decode.sv
module vpw_sym_decode #(
  parameter int CNT_W     = 9,
  parameter int LIM_MIN   = 34,
  parameter int LIM_SPLIT = 96,
  parameter int LIM_EOD   = 163,
  parameter int LIM_IDLE  = 239
) (
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [2:0]       cls_o
);
  import vpw_pkg::*;

  localparam logic [CNT_W-1:0] B_MIN   = CNT_W'(LIM_MIN);
  localparam logic [CNT_W-1:0] B_SPLIT = CNT_W'(LIM_SPLIT);
  localparam logic [CNT_W-1:0] B_EOD   = CNT_W'(LIM_EOD);
  localparam logic [CNT_W-1:0] B_IDLE  = CNT_W'(LIM_IDLE);

  logic [2:0] bin;

  always_comb begin
    if      (cnt_i < B_MIN)   bin = 3'd0;
    else if (cnt_i < B_SPLIT) bin = 3'd1;
    else if (cnt_i < B_EOD)   bin = 3'd2;
    else if (cnt_i < B_IDLE)  bin = 3'd3;
    else                      bin = 3'd4;
  end

  always_comb begin
    case (bin)
      3'd1:    cls_o = (lvl_i == LVL_ACTIVE) ? CLS_BIT1  : CLS_BIT0;
      3'd2:    cls_o = (lvl_i == LVL_ACTIVE) ? CLS_BIT0  : CLS_BIT1;
      3'd3:    cls_o = (lvl_i == LVL_ACTIVE) ? CLS_SOF   : CLS_EOD;
      3'd4:    cls_o = (lvl_i == LVL_ACTIVE) ? CLS_BREAK : CLS_IDLE;
      default: cls_o = CLS_INVALID;
    endcase
  end

endmodule

// File: rtl/vpw_gap_watch.sv
module vpw_gap_watch #(
  parameter int CNT_W    = 9,
  parameter int LIM_EOD  = 163,
  parameter int LIM_IDLE = 239
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_q,
  input  logic             edge_det,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             eod_strobe,
  output logic             idle_strobe
);
  import vpw_pkg::*;

  localparam logic [CNT_W-1:0] EOD_PRE  = CNT_W'(LIM_EOD - 1);
  localparam logic [CNT_W-1:0] IDLE_PRE = CNT_W'(LIM_IDLE - 1);

  logic quiet_passive;
  logic eod_d;
  logic idle_d;

  always_comb begin
    quiet_passive = !edge_det && (lvl_q == LVL_PASSIVE);
    eod_d         = quiet_passive && (cnt_q == EOD_PRE);
    idle_d        = quiet_passive && (cnt_q == IDLE_PRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eod_strobe  <= 1'b0;
      idle_strobe <= 1'b0;
    end else begin
      eod_strobe  <= eod_d;
      idle_strobe <= idle_d;
    end
  end

  // R9
  eod_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_strobe |=> !eod_strobe);

  // R9
  eod_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eod_strobe |-> (cnt_q == CNT_W'(LIM_EOD) && lvl_q == LVL_PASSIVE));

  // R10
  idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_strobe |=> !idle_strobe);

  // R10
  idle_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_strobe |-> (cnt_q == CNT_W'(LIM_IDLE) && lvl_q == LVL_PASSIVE));

endmodule

// File: rtl/vpw_sym_classifier.sv
module vpw_sym_classifier #(
  parameter int CNT_W     = 9,
  parameter int LIM_MIN   = 34,
  parameter int LIM_SPLIT = 96,
  parameter int LIM_EOD   = 163,
  parameter int LIM_IDLE  = 239
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_in,
  output logic       sym_valid,
  output logic       sym_level,
  output logic [2:0] sym_class,
  output logic       eod_strobe,
  output logic       idle_strobe
);
  import vpw_pkg::*;

  logic             rst_meta;
  logic             rst_sync_n;
  logic             lvl_q;
  logic             edge_det;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       cls_d;
  logic             out_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  vpw_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_in   (bus_in),
    .lvl_q    (lvl_q),
    .edge_det (edge_det),
    .cnt_q    (cnt_q)
  );

  vpw_sym_decode #(
    .CNT_W(CNT_W), .LIM_MIN(LIM_MIN), .LIM_SPLIT(LIM_SPLIT),
    .LIM_EOD(LIM_EOD), .LIM_IDLE(LIM_IDLE)
  ) u_dec (
    .lvl_i (lvl_q),
    .cnt_i (cnt_q),
    .cls_o (cls_d)
  );

  vpw_gap_watch #(.CNT_W(CNT_W), .LIM_EOD(LIM_EOD), .LIM_IDLE(LIM_IDLE)) u_gap (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .lvl_q       (lvl_q),
    .edge_det    (edge_det),
    .cnt_q       (cnt_q),
    .eod_strobe  (eod_strobe),
    .idle_strobe (idle_strobe)
  );

  assign out_en = edge_det;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sym_valid <= 1'b0;
      sym_level <= LVL_PASSIVE;
      sym_class <= CLS_INVALID;
    end else begin
      sym_valid <= edge_det;
      if (out_en) begin
        sym_level <= lvl_q;
        sym_class <= cls_d;
      end
    end
  end

  // R6
  idle_passive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sym_valid && sym_class == CLS_IDLE) |-> (sym_level == LVL_PASSIVE));

  // R7
  sof_active_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sym_valid && sym_class == CLS_SOF) |-> (sym_level == LVL_ACTIVE));

  // R2
  level_flip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sym_valid |-> (sym_level != lvl_q));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sym_valid |-> !(eod_strobe || idle_strobe));

endmodule

// File: tb/sim_vpw_sym_classifier.sv
module sim_vpw_sym_classifier;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    kind;
    logic  lvl;
    logic [2:0] cls;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_in;
  logic       sym_valid;
  logic       sym_level;
  logic [2:0] sym_class;
  logic       eod_strobe;
  logic       idle_strobe;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpw_sym_classifier u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .sym_valid(sym_valid), .sym_level(sym_level), .sym_class(sym_class),
    .eod_strobe(eod_strobe), .idle_strobe(idle_strobe)
  );

  function automatic logic [2:0] ref_cls(input logic lvl, input int n);
    if (n < 34)  return 3'd0;
    if (n < 96)  return lvl ? 3'd2 : 3'd1;
    if (n < 163) return lvl ? 3'd1 : 3'd2;
    if (n < 239) return lvl ? 3'd4 : 3'd3;
    return lvl ? 3'd6 : 3'd5;
  endfunction

  function automatic string ref_tag(input logic lvl, input int n);
    if (n >= 512) return "R8";
    if (n < 34)   return "R3";
    if (n < 163)  return lvl ? "R5" : "R4";
    return lvl ? "R7" : "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: called at a negedge; holds the level for n rising edges.
  task automatic iv(input logic lvl, input int n, input bit emit);
    exp_t e;
    bus_in = lvl;
    if (!lvl && n >= 163) begin
      e.kind = 1; e.lvl = 1'b0; e.cls = 3'd0; e.tag = "R9";
      exp_q.push_back(e);
    end
    if (!lvl && n >= 239) begin
      e.kind = 2; e.lvl = 1'b0; e.cls = 3'd0; e.tag = "R10";
      exp_q.push_back(e);
    end
    if (emit) begin
      e.kind = 0; e.lvl = lvl; e.cls = ref_cls(lvl, n); e.tag = ref_tag(lvl, n);
      exp_q.push_back(e);
    end
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per observed event.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sym_valid || eod_strobe || idle_strobe) begin
        exp_t e;
        int kind_act;
        kind_act = sym_valid ? 0 : (eod_strobe ? 1 : 2);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 actual=event%0d expected=none", kind_act);
        end else begin
          e = exp_q.pop_front();
          check(e.tag, kind_act, e.kind);
          if (kind_act == 0 && e.kind == 0) begin
            check("R2", int'(sym_level), int'(e.lvl));
            check(e.tag, int'(sym_class), int'(e.cls));
          end
        end
      end
    end
  end

  initial begin
    rst_n  = 1'b0;
    bus_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    check("R1", int'(sym_valid), 0);
    check("R1", int'(eod_strobe), 0);
    check("R1", int'(idle_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sym_valid), 0);
    iv(1'b0, 300, 1'b1);          // start-up passive stretch: R6 idle, R9, R10
    iv(1'b1, 33, 1'b1);   iv(1'b0, 33, 1'b1);    // R3
    iv(1'b1, 34, 1'b1);   iv(1'b0, 34, 1'b1);    // R5, R4
    iv(1'b1, 95, 1'b1);   iv(1'b0, 95, 1'b1);
    iv(1'b1, 96, 1'b1);   iv(1'b0, 96, 1'b1);
    iv(1'b1, 162, 1'b1);  iv(1'b0, 162, 1'b1);   // R9: no strobe at 162
    iv(1'b1, 163, 1'b1);  iv(1'b0, 163, 1'b1);   // R7, R6, R9
    iv(1'b1, 238, 1'b1);  iv(1'b0, 238, 1'b1);   // R10: no strobe at 238
    iv(1'b1, 239, 1'b1);  iv(1'b0, 239, 1'b1);
    iv(1'b1, 600, 1'b1);                         // R8 saturation
    iv(1'b0, 1, 1'b1);    iv(1'b1, 1, 1'b1);     // back-to-back edges, R3
    iv(1'b0, 250, 1'b0);                         // trailing gap strobes
    repeat (4) @(negedge clk);
    check("R2", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule